// File: doc/BRIEF.md
# Serial Receive Path with Tagged Character Queue

This block turns an asynchronous serial input line into a queue of received characters. A baud generator outside the block supplies a 16x oversampling enable. An optional divide-by-four stage can thin out that enable. The receiver looks for a start bit and confirms it at mid-bit. It then gathers eight data bits, least significant bit first, an optional parity bit and one stop bit.

Each finished character enters a 32-deep queue. Its parity, framing and break tags are stored with it in the same entry. The host sees the oldest character, that character's own tags, a data-ready flag and a sticky overrun flag. It removes the oldest entry with a one-cycle pop strobe, and it clears overrun with a status-read strobe.

A line held low for a whole frame counts as a break. A break yields exactly one queue entry, however long the line stays low. When the queue is full, a new character is dropped rather than written, so the stored characters stay intact.

Top module: `serial_rx_path`

## Requirements
- R1: After reset the queue is empty, `data_ready` is 0 and `overrun` is 0. `data_ready` is 1 exactly when at least one character is queued.
- R2: A frame is one low start bit, eight data bits sent LSB first, a parity bit when `par_en`=1, and one stop bit, each 16 enable ticks long. Characters reach `rd_data` in arrival order.
- R3: When `par_en`=1, `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. A character whose data and parity bits disagree with the selected sense is stored with its parity tag set.
- R4: `err_parity`, `err_frame` and `err_break` describe the character at the queue head, not the latest arrival. They change when that entry is popped.
- R5: A character whose stop bit samples low is stored with its framing tag set.
- R6: A character that completes while the queue holds 32 entries is not written, and the stored entries are unchanged. `overrun` then rises and stays 1 until `stat_rd` is pulsed.
- R7: A line held low through start, data, parity and stop times stores exactly one entry: data 0x00 with the break tag and the framing tag both set. Reception resumes only after the line has returned high.
- R8: A start bit that is high again at its mid-bit sample is ignored, and no character is stored.
- R9: With `div4_sel`=1, only every fourth enable tick is used, so each bit lasts 64 enable ticks.
- R10: A pop strobe while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | 16x oversampling enable from the baud generator |
| div4_sel | input | 1 | 1 = use every fourth enable tick |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rxd | input | 1 | Serial input line, idle high |
| rd_pop | input | 1 | Removes the head character |
| stat_rd | input | 1 | Status read strobe, clears overrun |
| rd_data | output | 8 | Head character (0 when empty) |
| data_ready | output | 1 | Queue is not empty |
| overrun | output | 1 | Sticky overrun flag |
| err_parity | output | 1 | Parity tag of the head character |
| err_frame | output | 1 | Framing tag of the head character |
| err_break | output | 1 | Break tag of the head character |

## Verification
The bench goes after a full queue that receives two more characters. A design that wrote on full would show a corrupted head or lose one of the 32 stored values, and a non-sticky flag would drop `overrun` before the status read. It places a bad-parity character ahead of a clean one. A design that kept line-wide error flags would then tag the wrong character. A long break is followed by a normal character: a receiver that re-armed while the line was low would queue several break entries. Short start glitches and pops on an empty queue are also applied, and a wrong design would store a phantom character or underflow its pointers.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int RX_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } rx_state_e;

  typedef struct packed {
    logic             brk;
    logic             ferr;
    logic             perr;
    logic [RX_DW-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic os_tick,
  input  logic div_sel,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (os_tick) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick = os_tick & (~div_sel | (cnt_q == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rxp_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic      par_en,
  input  logic      par_odd,
  output logic      done,
  output rx_entry_t entry
);
  localparam int CW = $clog2(OS);
  localparam int IW = $clog2(RX_DW);
  localparam logic [CW-1:0] MID  = CW'(OS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OS - 1);

  rx_state_e        st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [RX_DW-1:0] sh_q, sh_d;
  logic             pb_q, pb_d;
  logic             zero_q, zero_d;
  logic             at_end, brk;

  assign at_end = tick && (cnt_q == LAST);
  assign brk    = zero_q && !rxd;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    pb_d   = pb_q;
    zero_d = zero_q;
    done   = 1'b0;
    case (st_q)
      ST_IDLE: if (tick && !rxd) begin
        st_d   = ST_START;
        cnt_d  = '0;
        zero_d = 1'b1;
        pb_d   = 1'b0;
      end
      ST_START: if (tick) begin
        if (cnt_q == MID) begin
          cnt_d = '0;
          idx_d = '0;
          st_d  = rxd ? ST_IDLE : ST_DATA;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_DATA: if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (at_end) begin
          sh_d  = {rxd, sh_q[RX_DW-1:1]};
          idx_d = idx_q + 1'b1;
          if (rxd) zero_d = 1'b0;
          if (idx_q == IW'(RX_DW - 1)) st_d = par_en ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR: if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (at_end) begin
          pb_d = rxd;
          if (rxd) zero_d = 1'b0;
          st_d = ST_STOP;
        end
      end
      ST_STOP: if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (at_end) begin
          done = 1'b1;
          st_d = brk ? ST_BRK : ST_IDLE;
        end
      end
      ST_BRK: if (rxd) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    entry.brk  = brk;
    entry.ferr = !rxd;
    entry.perr = par_en && !brk && ((^sh_q) ^ pb_q ^ par_odd);
    entry.data = brk ? '0 : sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pb_q   <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      pb_q   <= pb_d;
      zero_q <= zero_d;
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   n_q, n_d;
  logic          wr_ok, rd_ok;

  assign empty = (n_q == '0);
  assign full  = (n_q == (AW+1)'(DEPTH));
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign head  = mem_q[rp_q];

  always_comb begin
    wp_d = wr_ok ? wp_q + 1'b1 : wp_q;
    rp_d = rd_ok ? rp_q + 1'b1 : rp_q;
    n_d  = n_q;
    if (wr_ok && !rd_ok)      n_d = n_q + 1'b1;
    else if (rd_ok && !wr_ok) n_d = n_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      n_q  <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
      n_q  <= n_d;
    end
  end
endmodule

// File: rtl/serial_rx_path.sv
module serial_rx_path
  import rxp_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int OS    = 16,
  parameter int PRE   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             div4_sel,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             rxd,
  input  logic             rd_pop,
  input  logic             stat_rd,
  output logic [RX_DW-1:0] rd_data,
  output logic             data_ready,
  output logic             overrun,
  output logic             err_parity,
  output logic             err_frame,
  output logic             err_break
);
  localparam int EW = $bits(rx_entry_t);

  logic [1:0] rs_q;
  logic       rst_i;
  logic [1:0] rx_q;
  logic       tick, done, push, fifo_full, fifo_empty;
  logic       ovr_q, ovr_d;
  rx_entry_t  new_ent, head_ent;
  logic [EW-1:0] head_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rx_q <= 2'b11;
    else        rx_q <= {rx_q[0], rxd};
  end

  rx_tick_gen #(.DIV(PRE)) u_tick (
    .clk(clk), .rst_n(rst_i), .os_tick(os_tick), .div_sel(div4_sel), .tick(tick)
  );

  rx_framer #(.OS(OS)) u_frm (
    .clk(clk), .rst_n(rst_i), .tick(tick), .rxd(rx_q[1]),
    .par_en(par_en), .par_odd(par_odd), .done(done), .entry(new_ent)
  );

  assign push = done && !fifo_full;

  rx_fifo #(.DEPTH(DEPTH), .W(EW)) u_q (
    .clk(clk), .rst_n(rst_i), .push(push), .din(new_ent),
    .pop(rd_pop), .head(head_raw), .empty(fifo_empty), .full(fifo_full)
  );

  assign head_ent = fifo_empty ? '0 : rx_entry_t'(head_raw);

  always_comb ovr_d = (ovr_q && !stat_rd) || (done && fifo_full);

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign rd_data    = head_ent.data;
  assign err_parity = head_ent.perr;
  assign err_frame  = head_ent.ferr;
  assign err_break  = head_ent.brk;
  assign data_ready = !fifo_empty;
  assign overrun    = ovr_q;
endmodule

module serial_rx_path_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       push,
  input logic       full,
  input logic       rd_pop,
  input logic       stat_rd,
  input logic       data_ready,
  input logic       overrun,
  input logic [7:0] rd_data,
  input logic       err_frame,
  input logic       err_break
);
  // R1
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready && !push) |=> !data_ready);
  // R1
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> data_ready);
  // R6
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !stat_rd) |=> overrun);
  // R6
  full_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_pop) |=> $stable(rd_data));
  // R7
  break_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_break |-> (err_frame && rd_data == 8'h00));
endmodule

bind serial_rx_path serial_rx_path_chk u_chk (
  .clk(clk), .rst_n(rst_i), .push(push), .full(fifo_full),
  .rd_pop(rd_pop), .stat_rd(stat_rd), .data_ready(data_ready),
  .overrun(overrun), .rd_data(rd_data), .err_frame(err_frame),
  .err_break(err_break)
);

// File: tb/sim_serial_rx_path.sv
module sim_serial_rx_path;
  logic       clk = 1'b0;
  logic       rst_n, os_tick, div4_sel, par_en, par_odd, rxd, rd_pop, stat_rd;
  logic [7:0] rd_data;
  logic       data_ready, overrun, err_parity, err_frame, err_break;
  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_rx_path u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .div4_sel(div4_sel),
    .par_en(par_en), .par_odd(par_odd), .rxd(rxd), .rd_pop(rd_pop),
    .stat_rd(stat_rd), .rd_data(rd_data), .data_ready(data_ready),
    .overrun(overrun), .err_parity(err_parity), .err_frame(err_frame),
    .err_break(err_break)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic line(input logic b, input int len);
    rxd = b;
    repeat (len) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic flip, input logic stopv, input int bl);
    line(1'b0, bl);
    for (int i = 0; i < 8; i++) line(d[i], bl);
    if (par_en) line((^d) ^ par_odd ^ flip, bl);
    line(stopv, bl);
    line(1'b1, 2 * bl);
  endtask

  task automatic pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic head(input string req, input logic [7:0] d, input logic pe, input logic fe, input logic br);
    chk({req, " ready"}, data_ready, 1'b1);
    chk({req, " data"}, rd_data, d);
    chk({req, " perr"}, err_parity, pe);
    chk({req, " ferr"}, err_frame, fe);
    chk({req, " brk"}, err_break, br);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; os_tick = 1'b1; div4_sel = 1'b0; par_en = 1'b1; par_odd = 1'b0;
    rxd = 1'b1; rd_pop = 1'b0; stat_rd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk("R1 reset ready", data_ready, 1'b0);
    chk("R1 reset overrun", overrun, 1'b0);

    // R2 R3 sweep of every byte under mixed parity settings
    for (int v = 0; v < 256; v++) begin
      par_en  = (v % 3) != 0;
      par_odd = v[1];
      send(v[7:0], 1'b0, 1'b1, 16);
      head("R2 sweep", v[7:0], 1'b0, 1'b0, 1'b0);
      pop();
      chk("R1 drained", data_ready, 1'b0);
    end

    // R3 wrong parity in both senses
    par_en = 1'b1;
    for (int s = 0; s < 2; s++) begin
      par_odd = s[0];
      send(8'h6B, 1'b1, 1'b1, 16);
      head("R3 bad parity", 8'h6B, 1'b1, 1'b0, 1'b0);
      pop();
    end
    par_odd = 1'b0;

    // R4 tags follow the head entry
    send(8'h33, 1'b1, 1'b1, 16);
    send(8'h44, 1'b0, 1'b1, 16);
    head("R4 first", 8'h33, 1'b1, 1'b0, 1'b0);
    pop();
    head("R4 second", 8'h44, 1'b0, 1'b0, 1'b0);
    pop();

    // R5 low stop bit
    send(8'h81, 1'b0, 1'b0, 16);
    head("R5 framing", 8'h81, 1'b0, 1'b1, 1'b0);
    pop();
    chk("R5 single entry", data_ready, 1'b0);

    // R6 overrun on full queue
    for (int k = 0; k < 32; k++) send(8'(k + 1), 1'b0, 1'b1, 16);
    chk("R6 no overrun at 32", overrun, 1'b0);
    send(8'hA5, 1'b0, 1'b1, 16);
    chk("R6 overrun set", overrun, 1'b1);
    send(8'h5A, 1'b0, 1'b1, 16);
    chk("R6 overrun sticky", overrun, 1'b1);
    chk("R6 head intact", rd_data, 8'h01);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    @(negedge clk);
    chk("R6 overrun cleared", overrun, 1'b0);
    for (int k = 0; k < 32; k++) begin
      chk("R6 stored value", rd_data, 8'(k + 1));
      pop();
    end
    chk("R6 dropped chars absent", data_ready, 1'b0);

    // R7 long break gives one entry, then normal reception
    line(1'b0, 3 * 11 * 16);
    line(1'b1, 32);
    head("R7 break", 8'h00, 1'b0, 1'b1, 1'b1);
    pop();
    chk("R7 one entry", data_ready, 1'b0);
    send(8'h5C, 1'b0, 1'b1, 16);
    head("R7 resume", 8'h5C, 1'b0, 1'b0, 1'b0);
    pop();

    // R8 short start glitch
    line(1'b0, 4);
    line(1'b1, 200);
    chk("R8 glitch ignored", data_ready, 1'b0);

    // R10 pop on empty
    pop();
    pop();
    chk("R10 still empty", data_ready, 1'b0);
    send(8'h7E, 1'b0, 1'b1, 16);
    head("R10 after empty pops", 8'h7E, 1'b0, 1'b0, 1'b0);
    pop();
    chk("R10 one entry", data_ready, 1'b0);

    // R9 divide-by-four
    div4_sel = 1'b1;
    send(8'hC3, 1'b0, 1'b1, 64);
    head("R9 div4", 8'hC3, 1'b0, 1'b0, 1'b0);
    pop();
    par_en = 1'b0;
    send(8'h1D, 1'b0, 1'b1, 64);
    head("R9 div4 no parity", 8'h1D, 1'b0, 1'b0, 1'b0);
    pop();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule